// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores received Ethernet frames in host memory by walking a circular, linked list of descriptors. Each descriptor is four 32-bit words at consecutive word addresses: a status word, a control word, a buffer address and the address of the next descriptor. The ring closes because the last entry links back to the first. The engine reads the descriptor at its current pointer. If the host has handed that descriptor over, the engine packs incoming bytes little-endian into 32-bit words and writes them into the buffer. It then writes back a status word that returns the descriptor to the host, and moves on to the linked descriptor.

Ownership is a handshake. When the engine finds a descriptor that the host still holds, it stops, raises a buffer-unavailable flag and discards received bytes until software pulses the polling-demand input. Frames longer than one buffer continue into the following descriptors, and status bits mark the first and last pieces. Software loads the ring pointer through a list-base write that the engine accepts only while it is stopped. The memory side is a word-wide port that allows one outstanding request, with byte enables for partial words.

Top module: `rxring_engine`

## Requirements
- R1: After reset the engine is stopped: no memory request, `rx_irq` and `buf_unavail` low, and `rx_ready` high, so any bytes that arrive are discarded.
- R2: A `list_base_wr` pulse while stopped loads the descriptor pointer, and the next fetch reads that address. A `list_base_wr` while active has no effect.
- R3: A `poll_demand` while stopped fetches the status, control, buffer and next words in that order, at pointer +0, +4, +8 and +12. If status bit 31 (ownership) is 0, only the status word is read, `buf_unavail` rises and no further request is made.
- R4: Byte k of the data stored in a descriptor goes to lane k mod 4 (lane 0 is bits 7:0) of the word at buffer + 4*(k/4). A final partial word is written with byte enables for only its filled lanes.
- R5: Status writeback goes to the descriptor's first word. Bit 31 is cleared, bits 27:16 hold the frame bytes received up to and including this descriptor, bit 11 marks the first descriptor of a frame and bit 10 the last.
- R6: On the last descriptor, bits 14/13/12 copy `rx_match[2:0]` (multicast, broadcast, own address), bits 6:2 copy `rx_err[4:0]` (runt, too long, alignment, CRC, receive error) and bit 7 is the OR of bits 6:2. On a descriptor that is not the last, bits 14:12 and 7:2 are zero.
- R7: The buffer size in bytes is control bits 10:0. When a buffer fills before the frame ends, the descriptor is written back as not-last and the frame continues in the next descriptor.
- R8: After writeback the engine follows the next-descriptor link, so a ring of descriptors wraps from the last entry to the first.
- R9: After writeback of a descriptor whose control bit 23 is set, `rx_irq` pulses high for exactly one cycle. Other descriptors give no pulse.
- R10: While stopped, `rx_ready` is high and received bytes are discarded with no memory write. A frame cut off by a stall is discarded up to its last byte. `poll_demand` clears `buf_unavail` and refetches at the same pointer, and the next frame starts with a first-flagged descriptor.
- R11: A `poll_demand` while the engine is active has no effect.
- R12: `mem_req` stays high with a stable address and direction until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| list_base_wr | input | 1 | Load descriptor pointer (taken only while stopped) |
| list_base_data | input | AW | Descriptor pointer value |
| poll_demand | input | 1 | Restart strobe |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Byte accepted (stored or discarded) on this edge |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Byte is the frame's final byte |
| rx_match | input | 3 | Address class {multicast, broadcast, own}, valid with rx_last |
| rx_err | input | 5 | Error class {runt, long, align, CRC, rx error}, valid with rx_last |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completes |
| rx_irq | output | 1 | One-cycle completion pulse |
| buf_unavail | output | 1 | Stopped on a host-owned descriptor |

## Verification
The hardest case to reach is a stall in the middle of a frame. The engine must already hold a valid descriptor and be partway through a frame longer than one buffer, and the descriptor it fetches next must belong to the host. The bench arranges this by clearing the ownership bit of the descriptor after the one the engine is holding, then sending a frame that overruns the held buffer. It then checks that the tail bytes produce no writes, that a restart resumes at the same pointer, and that the following frame is first-flagged. A sweep over frame lengths on a three-entry ring with a six-byte buffer also exercises splits, partial words, wrap-around and interrupt selection.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam int WORD_W    = 32;
    localparam int NLANE     = WORD_W / 8;
    localparam int LANE_W    = $clog2(NLANE);
    localparam int OWN_POS   = 31;
    localparam int LEN_POS   = 16;
    localparam int MATCH_POS = 12;
    localparam int FIRST_POS = 11;
    localparam int LAST_POS  = 10;
    localparam int SUM_POS   = 7;
    localparam int ERR_POS   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_CTRL,
        ST_RD_BUF,
        ST_RD_NEXT,
        ST_RECV,
        ST_WR_DATA,
        ST_WR_STAT
    } eng_state_e;

    typedef struct packed {
        logic mcast;
        logic bcast;
        logic self_hit;
    } match_t;

    typedef struct packed {
        logic runt;
        logic too_long;
        logic align;
        logic crc;
        logic phy;
    } rxerr_t;

    // word index inside a descriptor for each fetch state
    function automatic logic [1:0] fetch_word(eng_state_e s);
        case (s)
            ST_RD_CTRL: return 2'd1;
            ST_RD_BUF:  return 2'd2;
            ST_RD_NEXT: return 2'd3;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/rxr_packer.sv
module rxr_packer
    import rxring_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    take,
    input  logic [7:0]              din,
    input  logic                    clear,
    output logic [WORD_W-1:0]       word,
    output logic [NLANE-1:0]        be,
    output logic [LANE_W-1:0]       lane
);

    logic [NLANE-1:0][7:0] bytes_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            lane <= '0;
        end else if (take) begin
            lane <= lane + 1'b1;
        end
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                bytes_q[i] <= '0;
                be[i]      <= 1'b0;
            end else if (clear) begin
                be[i]      <= 1'b0;
            end else if (take && lane == LANE_W'(i)) begin
                bytes_q[i] <= din;
                be[i]      <= 1'b1;
            end
        end
    end

    assign word = bytes_q;

endmodule

// File: rtl/rxr_status_fmt.sv
module rxr_status_fmt
    import rxring_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic [LEN_W-1:0]  len,
    input  logic              first,
    input  logic              last,
    input  match_t            match,
    input  rxerr_t            err,
    output logic [WORD_W-1:0] status
);

    always_comb begin
        status                      = '0;
        status[LEN_POS +: LEN_W]    = len;
        status[FIRST_POS]           = first;
        status[LAST_POS]            = last;
        if (last) begin
            status[MATCH_POS +: 3]  = match;
            status[ERR_POS +: 5]    = err;
            status[SUM_POS]         = |err;
        end
        status[OWN_POS]             = 1'b0;
    end

endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
    import rxring_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LEN_W  = 12,
    parameter int BSZ_W  = 11,
    parameter int IC_BIT = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              list_base_wr,
    input  logic [AW-1:0]     list_base_data,
    input  logic              poll_demand,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic [2:0]        rx_match,
    input  logic [4:0]        rx_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              rx_irq,
    output logic              buf_unavail
);

    localparam int STEP = WORD_W / 8;

    eng_state_e          state;
    logic [AW-1:0]       ptr;
    logic [AW-1:0]       next_q;
    logic [AW-1:0]       waddr;
    logic [BSZ_W-1:0]    bsz_q;
    logic [BSZ_W-1:0]    bcnt;
    logic [LEN_W-1:0]    flen;
    logic                ic_q;
    logic                first_q;
    logic                end_q;
    logic                full_q;
    logic                drop_q;
    logic                unavail_q;
    logic                irq_q;
    match_t              match_q;
    rxerr_t              err_q;

    logic [WORD_W-1:0]   pk_word;
    logic [NLANE-1:0]    pk_be;
    logic [LANE_W-1:0]   pk_lane;
    logic [WORD_W-1:0]   stat_word;

    logic                take;
    logic                drop_byte;
    logic                flush;
    logic                buf_full_nx;
    logic                pk_clear;
    logic [BSZ_W:0]      bcnt_inc;

    assign bcnt_inc    = {1'b0, bcnt} + 1'b1;
    assign buf_full_nx = bcnt_inc >= {1'b0, bsz_q};
    assign rx_ready    = (state == ST_IDLE) || (state == ST_RECV);
    assign take        = (state == ST_RECV) && rx_valid && !drop_q;
    assign drop_byte   = rx_valid && ((state == ST_IDLE) || (state == ST_RECV && drop_q));
    assign flush       = take && (pk_lane == LANE_W'(NLANE - 1) || rx_last || buf_full_nx);
    assign pk_clear    = (state == ST_WR_DATA) && mem_ack;
    assign rx_irq      = irq_q;
    assign buf_unavail = unavail_q;

    rxr_packer u_packer (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .din   (rx_data),
        .clear (pk_clear),
        .word  (pk_word),
        .be    (pk_be),
        .lane  (pk_lane)
    );

    rxr_status_fmt #(.LEN_W(LEN_W)) u_stat (
        .len    (flen),
        .first  (first_q),
        .last   (end_q),
        .match  (match_q),
        .err    (err_q),
        .status (stat_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ptr       <= '0;
            next_q    <= '0;
            waddr     <= '0;
            bsz_q     <= '0;
            bcnt      <= '0;
            flen      <= '0;
            ic_q      <= 1'b0;
            first_q   <= 1'b1;
            end_q     <= 1'b0;
            full_q    <= 1'b0;
            drop_q    <= 1'b0;
            unavail_q <= 1'b0;
            irq_q     <= 1'b0;
            match_q   <= '0;
            err_q     <= '0;
        end else begin
            irq_q <= 1'b0;
            if (drop_byte) begin
                drop_q <= !rx_last;
            end
            case (state)
                ST_IDLE: begin
                    if (list_base_wr) begin
                        ptr <= list_base_data;
                    end
                    if (poll_demand) begin
                        unavail_q <= 1'b0;
                        state     <= ST_RD_STAT;
                    end
                end
                ST_RD_STAT: begin
                    if (mem_ack) begin
                        if (mem_rdata[OWN_POS]) begin
                            state <= ST_RD_CTRL;
                        end else begin
                            state     <= ST_IDLE;
                            unavail_q <= 1'b1;
                            drop_q    <= !first_q;
                            first_q   <= 1'b1;
                            flen      <= '0;
                            bcnt      <= '0;
                        end
                    end
                end
                ST_RD_CTRL: begin
                    if (mem_ack) begin
                        bsz_q <= mem_rdata[BSZ_W-1:0];
                        ic_q  <= mem_rdata[IC_BIT];
                        state <= ST_RD_BUF;
                    end
                end
                ST_RD_BUF: begin
                    if (mem_ack) begin
                        waddr <= {mem_rdata[AW-1:2], 2'b00};
                        state <= ST_RD_NEXT;
                    end
                end
                ST_RD_NEXT: begin
                    if (mem_ack) begin
                        next_q <= mem_rdata[AW-1:0];
                        bcnt   <= '0;
                        state  <= ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (take) begin
                        bcnt <= bcnt_inc[BSZ_W-1:0];
                        flen <= flen + 1'b1;
                        if (rx_last) begin
                            match_q <= rx_match;
                            err_q   <= rx_err;
                        end
                        if (flush) begin
                            end_q  <= rx_last;
                            full_q <= buf_full_nx;
                            state  <= ST_WR_DATA;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (mem_ack) begin
                        waddr <= waddr + AW'(STEP);
                        state <= (end_q || full_q) ? ST_WR_STAT : ST_RECV;
                    end
                end
                ST_WR_STAT: begin
                    if (mem_ack) begin
                        irq_q   <= ic_q;
                        ptr     <= next_q;
                        first_q <= end_q;
                        if (end_q) begin
                            flen <= '0;
                        end
                        state <= ST_RD_STAT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = stat_word;
        mem_be    = '1;
        case (state)
            ST_RD_STAT, ST_RD_CTRL, ST_RD_BUF, ST_RD_NEXT: begin
                mem_req  = 1'b1;
                mem_addr = ptr + AW'({fetch_word(state), 2'b00});
            end
            ST_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = waddr;
                mem_wdata = pk_word;
                mem_be    = pk_be;
            end
            ST_WR_STAT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rxring_engine_chk.sv
module rxring_engine_chk
    import rxring_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input eng_state_e    state,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic [3:0]    mem_be,
    input logic          rx_ready,
    input logic          rx_irq,
    input logic          buf_unavail
);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_owner_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_STAT && mem_req) |-> (mem_we && !mem_wdata[31]));

    p_err_summary_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_STAT && mem_req) |-> (mem_wdata[7] == (|mem_wdata[6:2])));

    p_nonlast_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_STAT && mem_req && !mem_wdata[10]) |->
        (mem_wdata[14:12] == 3'b000 && mem_wdata[7:2] == 6'd0));

    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);

    p_stall_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        buf_unavail |-> !mem_req);

    p_idle_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> rx_ready);

    p_lane0_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_be[0]);

endmodule

bind rxring_engine rxring_engine_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .state       (state),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_be      (mem_be),
    .rx_ready    (rx_ready),
    .rx_irq      (rx_irq),
    .buf_unavail (buf_unavail)
);

// File: tb/rxring_engine_test.sv
module rxring_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int BSZ        = 6;
    localparam int NDESC      = 3;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        list_base_wr = 1'b0;
    logic [31:0] list_base_data = '0;
    logic        poll_demand = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic [2:0]  rx_match = '0;
    logic [4:0]  rx_err = '0;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        rx_irq;
    logic        buf_unavail;

    rxring_engine uut (
        .clk            (clk),
        .rst            (rst),
        .list_base_wr   (list_base_wr),
        .list_base_data (list_base_data),
        .poll_demand    (poll_demand),
        .rx_valid       (rx_valid),
        .rx_ready       (rx_ready),
        .rx_data        (rx_data),
        .rx_last        (rx_last),
        .rx_match       (rx_match),
        .rx_err         (rx_err),
        .mem_req        (mem_req),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_be         (mem_be),
        .mem_rdata      (mem_rdata),
        .mem_ack        (mem_ack),
        .rx_irq         (rx_irq),
        .buf_unavail    (buf_unavail)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [31:0] mem [0:255];
    logic [31:0] rd_log [0:63];
    int rd_count = 0;
    int wr_count = 0;
    int irq_count = 0;
    int stab_err = 0;
    int wait_cnt = 0;
    int xact = 0;
    logic [31:0] hold_addr = '0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // memory responder and port monitor, acting on falling edges
    always @(negedge clk) begin
        if (rx_irq) irq_count++;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req && !rst) begin
            if (wait_cnt > 0 && mem_addr != hold_addr) stab_err++;
            hold_addr = mem_addr;
            if (wait_cnt >= xact % 3) begin
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] = mem_wdata[b*8 +: 8];
                    wr_count++;
                end else begin
                    mem_rdata = mem[mem_addr[9:2]];
                    rd_log[rd_count % 64] = mem_addr;
                    rd_count++;
                end
                mem_ack = 1'b1;
                wait_cnt = 0;
                xact++;
            end else begin
                wait_cnt++;
            end
        end
    end

    function automatic logic [31:0] desc_a(int i);
        return 32'h40 + 32'(16 * i);
    endfunction

    function automatic logic [31:0] buf_a(int i);
        return 32'h100 + 32'(64 * i);
    endfunction

    function automatic logic [7:0] byte_val(int len, int pos);
        return 8'((len * 16 + pos) & 255);
    endfunction

    function automatic logic [31:0] exp_stat(int len, int j);
        logic [31:0] s;
        int cum;
        bit lst;
        int e;
        cum = ((j + 1) * BSZ < len) ? (j + 1) * BSZ : len;
        lst = ((j + 1) * BSZ >= len);
        e   = (len * 3) % 32;
        s = 32'(cum) << 16;
        if (j == 0) s[11] = 1'b1;
        if (lst) begin
            s[10]    = 1'b1;
            s[14:12] = 3'(len % 8);
            s[6:2]   = 5'(e);
            s[7]     = (e != 0);
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic arm(input int i, input bit owned);
        mem[desc_a(i) >> 2]       = owned ? 32'h8000_0000 : 32'h0;
        mem[(desc_a(i) >> 2) + 1] = 32'(BSZ) | ((i == 1) ? 32'h0080_0000 : 32'h0);
        mem[(desc_a(i) >> 2) + 2] = buf_a(i);
        mem[(desc_a(i) >> 2) + 3] = desc_a((i + 1) % NDESC);
        for (int w = 0; w < 16; w++) mem[(buf_a(i) >> 2) + w] = 32'h0;
    endtask

    task automatic pulse_poll();
        @(negedge clk); poll_demand = 1'b1;
        @(negedge clk); poll_demand = 1'b0;
    endtask

    task automatic send_frame(input int len);
        for (int p = 0; p < len; p++) begin
            bit rdy;
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = byte_val(len, p);
            rx_last  = (p == len - 1);
            rx_match = 3'(len % 8);
            rx_err   = 5'((len * 3) % 32);
            do begin
                rdy = rx_ready;
                @(posedge clk);
                #1;
            end while (!rdy);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_frame(input int len, input int cur, input string tag);
        int k;
        k = (len + BSZ - 1) / BSZ;
        for (int j = 0; j < k; j++) begin
            int idx;
            int n;
            idx = (cur + j) % NDESC;
            n   = (len - j * BSZ < BSZ) ? len - j * BSZ : BSZ;
            check(mem[desc_a(idx) >> 2] == exp_stat(len, j), tag,
                  mem[desc_a(idx) >> 2], exp_stat(len, j));
            for (int w = 0; w < (BSZ + 3) / 4; w++) begin
                logic [31:0] ew;
                ew = '0;
                for (int l = 0; l < 4; l++)
                    if (w * 4 + l < n) ew[l*8 +: 8] = byte_val(len, j * BSZ + w * 4 + l);
                check(mem[(buf_a(idx) >> 2) + w] == ew, "R4 buffer word", mem[(buf_a(idx) >> 2) + w], ew);
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int cur;
        int rd0;
        int wr0;
        int irq0;
        for (int a = 0; a < 256; a++) mem[a] = 32'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(!mem_req, "R1 mem_req", 32'(mem_req), 0);
        check(!rx_irq, "R1 rx_irq", 32'(rx_irq), 0);
        check(!buf_unavail, "R1 buf_unavail", 32'(buf_unavail), 0);
        check(rx_ready, "R1 rx_ready", 32'(rx_ready), 1);

        for (int i = 0; i < NDESC; i++) arm(i, 1'b1);
        mem[desc_a(0) >> 2] = 32'h0;

        // R2 list base while stopped, R3 stall on host-owned descriptor
        @(negedge clk); list_base_wr = 1'b1; list_base_data = desc_a(0);
        @(negedge clk); list_base_wr = 1'b0;
        pulse_poll();
        idle_cycles(20);
        check(rd_count == 1, "R3 single read on host-owned", 32'(rd_count), 1);
        check(rd_log[0] == desc_a(0), "R2 fetch at list base", rd_log[0], desc_a(0));
        check(buf_unavail, "R10 buf_unavail set", 32'(buf_unavail), 1);

        // R10 bytes discarded while stopped
        wr0 = wr_count;
        send_frame(5);
        idle_cycles(5);
        check(wr_count == wr0, "R10 no write while stopped", 32'(wr_count), 32'(wr0));
        check(buf_unavail, "R10 flag held", 32'(buf_unavail), 1);

        // restart: R3 order, R10 clear
        mem[desc_a(0) >> 2] = 32'h8000_0000;
        pulse_poll();
        idle_cycles(20);
        check(!buf_unavail, "R10 flag cleared by poll", 32'(buf_unavail), 0);
        check(rd_count == 5, "R3 four fetch reads", 32'(rd_count), 5);
        for (int r = 1; r < 5; r++)
            check(rd_log[r] == desc_a(0) + 32'(4 * (r - 1)), "R3 fetch order",
                  rd_log[r], desc_a(0) + 32'(4 * (r - 1)));

        // sweep of frame lengths: R4 R5 R6 R7 R8 R9
        cur = 0;
        for (int len = 1; len <= 12; len++) begin
            int k;
            int eirq;
            k = (len + BSZ - 1) / BSZ;
            if (len == 4) begin
                rd0 = rd_count;
                pulse_poll();
                @(negedge clk); list_base_wr = 1'b1; list_base_data = 32'h300;
                @(negedge clk); list_base_wr = 1'b0;
                idle_cycles(10);
                check(rd_count == rd0, "R11 poll ignored while active", 32'(rd_count), 32'(rd0));
            end
            irq0 = irq_count;
            send_frame(len);
            idle_cycles(40);
            check_frame(len, cur, (len == 4) ? "R2 ignored base, R5 status" : "R5 R6 R7 R8 status");
            eirq = 0;
            for (int j = 0; j < k; j++) if ((cur + j) % NDESC == 1) eirq++;
            check(irq_count - irq0 == eirq, "R9 irq pulses", 32'(irq_count - irq0), 32'(eirq));
            for (int i = 0; i < NDESC; i++) arm(i, 1'b1);
            cur = (cur + k) % NDESC;
        end
        check(stab_err == 0, "R12 request stable until ack", 32'(stab_err), 0);

        // mid-frame stall: R7 R10
        mem[desc_a((cur + 1) % NDESC) >> 2] = 32'h0;
        wr0 = wr_count;
        send_frame(10);
        idle_cycles(20);
        check(mem[desc_a(cur) >> 2] == exp_stat(10, 0), "R7 split piece not last",
              mem[desc_a(cur) >> 2], exp_stat(10, 0));
        check(buf_unavail, "R10 stall mid-frame", 32'(buf_unavail), 1);
        check(wr_count - wr0 == 3, "R10 tail dropped", 32'(wr_count - wr0), 3);

        arm((cur + 1) % NDESC, 1'b1);
        pulse_poll();
        idle_cycles(20);
        send_frame(3);
        idle_cycles(40);
        check_frame(3, (cur + 1) % NDESC, "R10 restart first-flagged");
        check(!buf_unavail, "R10 running after restart", 32'(buf_unavail), 0);

        finish_run();
    end

endmodule